// File: doc/BRIEF.md
# Serial NOR Flash Configuration Register Unit

This block holds the configuration state of a serial NOR flash slave: a 16-bit nonvolatile configuration word, an 8-bit volatile configuration register, an 8-bit enhanced volatile register, the 4-byte address mode flag, the upper address segment register and the write-enable latch. A command sequencer that has already deserialised the SPI stream presents each transaction as an opcode strobe followed by data byte strobes, framed by an active-low chip select. The block answers the register read commands with response bytes and commits the register write commands. It also exposes the live mode state the sequencer needs for addressing and dummy-cycle timing.

A two-step software reset, an arm opcode followed by the reset opcode, rebuilds the volatile state field by field from the nonvolatile word. Hardware reset applies the same derivation to the default nonvolatile word. The memory array and the serial shift logic sit outside this block.

Top module: `nor_cfg_unit`

## Requirements
- R1: After hardware reset the nonvolatile word is 0x8FFF, vol_cfg is 0x83, enh_cfg is 0xDF, addr4_mode is 0, seg_addr is 0 and wel is 0.
- R2: Opcode 0xB5 returns the nonvolatile word as two bytes, bits [7:0] first, and 0x85 and 0x65 return vol_cfg and enh_cfg as one byte each. The first response byte is valid in the cycle after the opcode strobe, and each data strobe advances to the next byte. Past the last byte, rsp_valid is 0 and rsp_byte reads 0x00.
- R3: Opcode 0x70 returns one byte with bit7 = 1 and bit0 = addr4_mode. Its other bits are 0.
- R4: Opcode 0xB1 with two data bytes (bits [7:0] first), 0x81 with one byte and 0x61 with one byte write the nonvolatile word, vol_cfg and enh_cfg. Each of them, and 0xC5 (one byte to seg_addr), is accepted only when wel is 1 at the opcode. Otherwise the register keeps its value.
- R5: A write commits only when its last byte arrives. Raising cs_n before that leaves the register unchanged. Raising cs_n also ends a read response.
- R6: Opcode 0x06 sets wel and 0x04 clears it. Register writes do not change wel.
- R7: Opcode 0x99 performs a software reset only if the opcode immediately before it was 0x66. Deselects in between do not disarm. Any other opcode disarms.
- R8: On software reset, vol_cfg bits [1:0] become 1, bit3 becomes 1 only when nonvolatile bits [11:9] are not 3'b111, bits [7:4] are copied from nonvolatile bits [15:12], and bit2 is 0.
- R9: On software reset, enh_cfg becomes 0x1F plus bit6 = nonvolatile bit2 and bit7 = nonvolatile bit3. Bit5 is 0.
- R10: On software reset, nonvolatile bit0 = 0 sets addr4_mode and bit0 = 1 leaves it as it was. Nonvolatile bit1 = 0 loads seg_addr with (array bytes / 16 MiB) - 1, which is 3 by default, and bit1 = 1 leaves it as it was.
- R11: A software reset clears wel, pulses soft_rst high for one cycle (the cycle after the reset opcode) and leaves the nonvolatile word unchanged.
- R12: Opcode 0xB7 sets addr4_mode and 0xE9 clears it. Neither needs wel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| cs_n | input | 1 | Active-low chip select. High aborts the current command. |
| op_valid | input | 1 | Opcode strobe (takes precedence over dat_valid) |
| op_code | input | 8 | Opcode byte |
| dat_valid | input | 1 | Data byte strobe |
| dat_byte | input | 8 | Data byte |
| rsp_valid | output | 1 | A response byte is available |
| rsp_byte | output | 8 | Current response byte |
| wel | output | 1 | Write-enable latch |
| addr4_mode | output | 1 | 4-byte address mode |
| seg_addr | output | SEG_W | Upper address segment |
| vol_cfg | output | 8 | Volatile configuration (dummy count in [7:4]) |
| enh_cfg | output | 8 | Enhanced volatile configuration |
| soft_rst | output | 1 | One-cycle pulse after a software reset |

## Verification
Some rules are checked by assertions on every cycle. A change of the nonvolatile word is always preceded by a set write-enable latch. A software reset pulse always follows a reset opcode and always coincides with a cleared latch and the fixed low bits of both volatile registers. A deselect always ends a read response. Only the bench scenarios can show the full field-by-field derivation for chosen nonvolatile words, the preserve-versus-load choice for the address mode and the segment register, the byte order of the two-byte read, and the refusal of an interrupted or unlatched write.

// File: rtl/nor_cfg_pkg.sv
package nor_cfg_pkg;

    localparam logic [7:0] OP_WREN    = 8'h06;
    localparam logic [7:0] OP_WRDI    = 8'h04;
    localparam logic [7:0] OP_RD_NV   = 8'hB5;
    localparam logic [7:0] OP_WR_NV   = 8'hB1;
    localparam logic [7:0] OP_RD_VOL  = 8'h85;
    localparam logic [7:0] OP_WR_VOL  = 8'h81;
    localparam logic [7:0] OP_RD_ENH  = 8'h65;
    localparam logic [7:0] OP_WR_ENH  = 8'h61;
    localparam logic [7:0] OP_RD_FLAG = 8'h70;
    localparam logic [7:0] OP_ARM     = 8'h66;
    localparam logic [7:0] OP_RST     = 8'h99;
    localparam logic [7:0] OP_A4_ON   = 8'hB7;
    localparam logic [7:0] OP_A4_OFF  = 8'hE9;
    localparam logic [7:0] OP_WR_SEG  = 8'hC5;

    localparam int SEG_SHIFT = 24;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_READ  = 2'd1,
        PH_WRITE = 2'd2
    } phase_e;

    // REG_AUX means the flag byte for reads and the segment register for writes
    typedef enum logic [1:0] {
        REG_NV  = 2'd0,
        REG_VOL = 2'd1,
        REG_ENH = 2'd2,
        REG_AUX = 2'd3
    } reg_e;

endpackage

// File: rtl/nor_cfg_reset_map.sv
module nor_cfg_reset_map (
    input  logic [15:0] nv_word,
    output logic [7:0]  vol_img,
    output logic [7:0]  enh_img,
    output logic        a4_force,
    output logic        seg_load
);
    always_comb begin
        vol_img       = 8'h03;
        vol_img[3]    = (nv_word[11:9] != 3'b111);
        vol_img[7:4]  = nv_word[15:12];
        enh_img       = 8'h1F;
        enh_img[6]    = nv_word[2];
        enh_img[7]    = nv_word[3];
        a4_force      = ~nv_word[0];
        seg_load      = ~nv_word[1];
    end
endmodule

// File: rtl/nor_cfg_resp.sv
module nor_cfg_resp
    import nor_cfg_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_read,
    input  reg_e        sel,
    input  logic [1:0]  idx,
    input  logic [15:0] nv_word,
    input  logic [7:0]  vol_cfg,
    input  logic [7:0]  enh_cfg,
    input  logic        addr4,
    output logic        rsp_valid,
    output logic [7:0]  rsp_byte
);
    logic [1:0] len;

    always_comb begin
        len       = (sel == REG_NV) ? 2'd2 : 2'd1;
        rsp_valid = in_read && (idx < len);
        rsp_byte  = 8'h00;
        if (rsp_valid) begin
            case (sel)
                REG_NV:  rsp_byte = (idx == 2'd0) ? nv_word[7:0] : nv_word[15:8];
                REG_VOL: rsp_byte = vol_cfg;
                REG_ENH: rsp_byte = enh_cfg;
                default: rsp_byte = {1'b1, 6'b000000, addr4};
            endcase
        end
    end

    // R2: no response byte is offered past the second slot
    a_r2_within_count: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (idx <= 2'd1));
endmodule

// File: rtl/nor_cfg_unit.sv
module nor_cfg_unit
    import nor_cfg_pkg::*;
#(
    parameter int unsigned ARRAY_BYTES = 32'h0400_0000,
    parameter int          SEG_W       = 8,
    parameter logic [15:0] NV_DEFAULT  = 16'h8FFF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             op_valid,
    input  logic [7:0]       op_code,
    input  logic             dat_valid,
    input  logic [7:0]       dat_byte,
    output logic             rsp_valid,
    output logic [7:0]       rsp_byte,
    output logic             wel,
    output logic             addr4_mode,
    output logic [SEG_W-1:0] seg_addr,
    output logic [7:0]       vol_cfg,
    output logic [7:0]       enh_cfg,
    output logic             soft_rst
);
    localparam int unsigned SEG_COUNT = ARRAY_BYTES >> SEG_SHIFT;
    localparam logic [SEG_W-1:0] SEG_TOP =
        (SEG_COUNT == 0) ? '0 : SEG_W'(SEG_COUNT - 1);

    typedef struct packed {
        phase_e           phase;
        reg_e             sel;
        logic [1:0]       cnt;
        logic [7:0]       lo;
        logic             armed;
        logic             wel;
        logic             addr4;
        logic [SEG_W-1:0] seg;
        logic [15:0]      nv;
        logic [7:0]       vol;
        logic [7:0]       enh;
        logic             srst;
    } st_t;

    st_t q, d, por;

    logic [7:0] live_vol, live_enh, por_vol, por_enh;
    logic       live_a4, live_seg, por_a4, por_seg;

    nor_cfg_reset_map live_map_i (
        .nv_word (q.nv),
        .vol_img (live_vol),
        .enh_img (live_enh),
        .a4_force(live_a4),
        .seg_load(live_seg)
    );

    nor_cfg_reset_map por_map_i (
        .nv_word (NV_DEFAULT),
        .vol_img (por_vol),
        .enh_img (por_enh),
        .a4_force(por_a4),
        .seg_load(por_seg)
    );

    always_comb begin
        por       = '0;
        por.phase = PH_IDLE;
        por.sel   = REG_NV;
        por.nv    = NV_DEFAULT;
        por.vol   = por_vol;
        por.enh   = por_enh;
        por.addr4 = por_a4;
        por.seg   = por_seg ? SEG_TOP : '0;
    end

    always_comb begin
        d      = q;
        d.srst = 1'b0;
        if (cs_n) begin
            d.phase = PH_IDLE;
            d.cnt   = 2'd0;
        end else if (op_valid) begin
            d.phase = PH_IDLE;
            d.cnt   = 2'd0;
            d.armed = (op_code == OP_ARM);
            case (op_code)
                OP_WREN:    d.wel   = 1'b1;
                OP_WRDI:    d.wel   = 1'b0;
                OP_A4_ON:   d.addr4 = 1'b1;
                OP_A4_OFF:  d.addr4 = 1'b0;
                OP_RD_NV:   begin d.phase = PH_READ; d.sel = REG_NV;  end
                OP_RD_VOL:  begin d.phase = PH_READ; d.sel = REG_VOL; end
                OP_RD_ENH:  begin d.phase = PH_READ; d.sel = REG_ENH; end
                OP_RD_FLAG: begin d.phase = PH_READ; d.sel = REG_AUX; end
                OP_WR_NV:   if (q.wel) begin d.phase = PH_WRITE; d.sel = REG_NV;  end
                OP_WR_VOL:  if (q.wel) begin d.phase = PH_WRITE; d.sel = REG_VOL; end
                OP_WR_ENH:  if (q.wel) begin d.phase = PH_WRITE; d.sel = REG_ENH; end
                OP_WR_SEG:  if (q.wel) begin d.phase = PH_WRITE; d.sel = REG_AUX; end
                OP_RST: begin
                    if (q.armed) begin
                        d.vol  = live_vol;
                        d.enh  = live_enh;
                        d.wel  = 1'b0;
                        d.srst = 1'b1;
                        if (live_a4)  d.addr4 = 1'b1;
                        if (live_seg) d.seg   = SEG_TOP;
                    end
                end
                default: ;
            endcase
        end else if (dat_valid) begin
            case (q.phase)
                PH_READ: begin
                    if (q.cnt != 2'd3) d.cnt = q.cnt + 2'd1;
                end
                PH_WRITE: begin
                    d.phase = PH_IDLE;
                    case (q.sel)
                        REG_NV: begin
                            if (q.cnt == 2'd0) begin
                                d.lo    = dat_byte;
                                d.cnt   = 2'd1;
                                d.phase = PH_WRITE;
                            end else begin
                                d.nv = {dat_byte, q.lo};
                            end
                        end
                        REG_VOL: d.vol = dat_byte;
                        REG_ENH: d.enh = dat_byte;
                        default: d.seg = dat_byte[SEG_W-1:0];
                    endcase
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= por;
        else        q <= d;
    end

    nor_cfg_resp resp_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_read  (q.phase == PH_READ),
        .sel      (q.sel),
        .idx      (q.cnt),
        .nv_word  (q.nv),
        .vol_cfg  (q.vol),
        .enh_cfg  (q.enh),
        .addr4    (q.addr4),
        .rsp_valid(rsp_valid),
        .rsp_byte (rsp_byte)
    );

    assign wel        = q.wel;
    assign addr4_mode = q.addr4;
    assign seg_addr   = q.seg;
    assign vol_cfg    = q.vol;
    assign enh_cfg    = q.enh;
    assign soft_rst   = q.srst;

    // R4: the nonvolatile word only moves while the latch was set
    a_r4_nv_needs_wel: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.nv) |-> $past(q.wel));

    // R7: a reset pulse is always the answer to a reset opcode
    a_r7_pulse_after_opcode: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |-> $past(!cs_n && op_valid && op_code == OP_RST));

    // R11: reset leaves the latch cleared
    a_r11_reset_drops_wel: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |-> !wel);

    // R8: fixed low bits of the volatile register after reset
    a_r8_vol_fixed_bits: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |-> (vol_cfg[1:0] == 2'b11 && vol_cfg[2] == 1'b0));

    // R9: fixed low bits of the enhanced register after reset
    a_r9_enh_fixed_bits: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |-> (enh_cfg[4:0] == 5'h1F && enh_cfg[5] == 1'b0));

    // R5: a deselect ends any response
    a_r5_deselect_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> !rsp_valid);
endmodule

// File: tb/nor_cfg_unit_tb_top.sv
module nor_cfg_unit_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       op_valid = 1'b0;
    logic [7:0] op_code = 8'h00;
    logic       dat_valid = 1'b0;
    logic [7:0] dat_byte = 8'h00;
    logic       rsp_valid, wel, addr4_mode, soft_rst;
    logic [7:0] rsp_byte, seg_addr, vol_cfg, enh_cfg;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    nor_cfg_unit dut_i (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n),
        .op_valid(op_valid), .op_code(op_code),
        .dat_valid(dat_valid), .dat_byte(dat_byte),
        .rsp_valid(rsp_valid), .rsp_byte(rsp_byte),
        .wel(wel), .addr4_mode(addr4_mode), .seg_addr(seg_addr),
        .vol_cfg(vol_cfg), .enh_cfg(enh_cfg), .soft_rst(soft_rst)
    );

    // {opcode, is_read, byte count, byte0, byte1}
    localparam int NVEC = 12;
    localparam logic [26:0] VEC [NVEC] = '{
        {8'h06, 1'b0, 2'd0, 8'h00, 8'h00},
        {8'hB1, 1'b0, 2'd2, 8'h34, 8'h12},
        {8'hB5, 1'b1, 2'd2, 8'h34, 8'h12},
        {8'h81, 1'b0, 2'd1, 8'hA5, 8'h00},
        {8'h85, 1'b1, 2'd1, 8'hA5, 8'h00},
        {8'h61, 1'b0, 2'd1, 8'h3C, 8'h00},
        {8'h65, 1'b1, 2'd1, 8'h3C, 8'h00},
        {8'h70, 1'b1, 2'd1, 8'h80, 8'h00},
        {8'hB7, 1'b0, 2'd0, 8'h00, 8'h00},
        {8'h70, 1'b1, 2'd1, 8'h81, 8'h00},
        {8'hE9, 1'b0, 2'd0, 8'h00, 8'h00},
        {8'h70, 1'b1, 2'd1, 8'h80, 8'h00}
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic send_op(input logic [7:0] op);
        @(negedge clk);
        cs_n = 1'b0; op_valid = 1'b1; op_code = op;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    task automatic send_dat(input logic [7:0] b);
        @(negedge clk);
        dat_valid = 1'b1; dat_byte = b;
        @(negedge clk);
        dat_valid = 1'b0;
    endtask

    task automatic deselect();
        @(negedge clk);
        cs_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic read_nv(input string req, input logic [15:0] exp);
        logic [7:0] lo;
        send_op(8'hB5);
        lo = rsp_byte;
        send_dat(8'h00);
        chk(req, {rsp_byte, lo}, exp);
        deselect();
    endtask

    task automatic do_reset_pair();
        send_op(8'h66);
        deselect();
        send_op(8'h99);
    endtask

    initial begin
        #(20ns * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", {8'h00, vol_cfg}, 16'h0083);
        chk("R1", {8'h00, enh_cfg}, 16'h00DF);
        chk("R1", {addr4_mode, wel, 6'b0, seg_addr}, 16'h0000);
        read_nv("R1", 16'h8FFF);

        // table walk
        for (int i = 0; i < NVEC; i++) begin
            logic [7:0] op, b0, b1;
            logic       rd;
            logic [1:0] nd;
            string      tag;
            {op, rd, nd, b0, b1} = VEC[i];
            tag = rd ? ((op == 8'h70) ? "R3" : "R2") : "R4";
            send_op(op);
            for (int k = 0; k < nd; k++) begin
                if (rd) begin
                    chk(tag, {7'b0, rsp_valid, rsp_byte}, {8'h01, (k == 0) ? b0 : b1});
                    send_dat(8'h00);
                end else begin
                    send_dat((k == 0) ? b0 : b1);
                end
            end
            deselect();
        end

        // R2 past the last byte
        send_op(8'h85);
        send_dat(8'h00);
        chk("R2", {7'b0, rsp_valid, rsp_byte}, 16'h0000);
        deselect();

        // R6 / R4 writes without latch
        send_op(8'h04); deselect();
        chk("R6", {15'b0, wel}, 16'h0000);
        send_op(8'h81); send_dat(8'h11); deselect();
        chk("R4", {8'h00, vol_cfg}, 16'h00A5);
        send_op(8'hC5); send_dat(8'h02); deselect();
        chk("R4", {8'h00, seg_addr}, 16'h0000);

        // R5 interrupted write and interrupted read
        send_op(8'h06); deselect();
        chk("R6", {15'b0, wel}, 16'h0001);
        send_op(8'hB1); send_dat(8'h77); deselect();
        read_nv("R5", 16'h1234);
        send_op(8'h85); deselect();
        chk("R5", {15'b0, rsp_valid}, 16'h0000);

        // R7 disarmed by an intervening opcode
        send_op(8'h66); deselect();
        send_op(8'h06); deselect();
        send_op(8'h99);
        chk("R7", {15'b0, soft_rst}, 16'h0000);
        deselect();
        chk("R7", {8'h00, vol_cfg}, 16'h00A5);

        // R8 R9 R10 R11 reset with loading word
        send_op(8'hB1); send_dat(8'h08); send_dat(8'h70); deselect();
        do_reset_pair();
        chk("R11", {14'b0, soft_rst, wel}, 16'h0002);
        chk("R8", {8'h00, vol_cfg}, 16'h007B);
        chk("R9", {8'h00, enh_cfg}, 16'h009F);
        chk("R10", {7'b0, addr4_mode, seg_addr}, 16'h0103);
        deselect();
        chk("R11", {15'b0, soft_rst}, 16'h0000);
        read_nv("R11", 16'h7008);

        // R10 keep path, R12 segment write and address mode
        send_op(8'h06); deselect();
        send_op(8'hC5); send_dat(8'h02); deselect();
        chk("R4", {8'h00, seg_addr}, 16'h0002);
        send_op(8'hB1); send_dat(8'h07); send_dat(8'h0E); deselect();
        do_reset_pair();
        deselect();
        chk("R8", {8'h00, vol_cfg}, 16'h0003);
        chk("R9", {8'h00, enh_cfg}, 16'h005F);
        chk("R10", {7'b0, addr4_mode, seg_addr}, 16'h0102);
        send_op(8'hE9); deselect();
        chk("R12", {15'b0, addr4_mode}, 16'h0000);
        send_op(8'hB7); deselect();
        chk("R12", {15'b0, addr4_mode}, 16'h0001);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule